// File: doc/BRIEF.md
# Multicycle Processor Control Unit

This block sequences a 32-bit multicycle processor that runs a small load/store instruction subset. One ALU and one shared instruction/data memory are used again and again across the steps of each instruction. The control unit decides, cycle by cycle, what those shared resources do. It takes the opcode and function fields of the held instruction and the ALU zero flag. It drives the datapath select lines, the write enables, a 3-bit ALU operation code and the program-counter load enable.

Internally a state register walks through fetch, decode and the instruction-specific execute, memory and writeback steps, one clock per step. A per-state decoder turns the current state into a control word. A small ALU decoder turns the requested operation class, plus the function field, into the ALU code. The program-counter enable merges the unconditional update request with the branch request gated by the zero flag.

Top module: `mcc_ctrl_unit`

## Requirements
- R1: While `rst_n` is low the unit is in the fetch step. Fetch drives `iord`=0, `alu_src_a`=0, `alu_src_b`=01 (constant 4), `pc_src`=00, `ir_wr`=1, `pc_en`=1 and `alu_ctrl`=010, so the PC advances by 4.
- R2: Opcode encodings are R-type 000000, ADDI 001000, LW 100011, SW 101011, BEQ 000100 and J 000010. Counted from fetch, BEQ and J take 3 cycles, R-type, ADDI and SW take 4, and LW takes 5. After the last cycle the next cycle is fetch.
- R3: Any other opcode returns from decode to fetch, with no register, memory or PC write in decode.
- R4: `iord`=1 only in the load read step and the store write step. It is 0 in fetch.
- R5: `ir_wr` is 1 only in fetch. `reg_wr` is 1 only in the three writeback steps (R-type, ADDI, LW). `mem_wr` is 1 only in the store write step.
- R6: Decode drives `alu_src_b`=11 (shifted immediate, branch target). The address step for LW/SW and the ADDI execute step drive `alu_src_a`=1 and `alu_src_b`=10. The R-type execute and BEQ compare steps drive `alu_src_a`=1 and `alu_src_b`=00.
- R7: R-type writeback drives `reg_dst`=1 (rd). ADDI and LW writeback drive `reg_dst`=0 (rt). `mem_to_reg`=1 only in LW writeback.
- R8: In the R-type execute step the function field sets `alu_ctrl`: 0x20 gives 010 (add), 0x22 gives 110 (sub), 0x24 gives 000 (and), 0x25 gives 001 (or), 0x2A gives 111 (slt), and any other value gives 010. The BEQ compare step drives 110. Every other step drives 010.
- R9: `pc_en` = unconditional PC write OR (branch AND `zero`). It is 1 in fetch and in the jump step. In the BEQ compare step it equals `zero`. In every other step it is 0 whatever `zero` is.
- R10: `pc_src` is 01 (ALU output register, branch target) in the BEQ compare step and 10 (jump address) in the J step. It is 00 in every other step.
- R11: Any select or enable that a step does not name in R1 to R10 is 0 in that step.
- R12: Lowering `rst_n` in the middle of an instruction puts the unit in fetch at once. After release the first cycle is fetch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Opcode field of the held instruction |
| funct | input | 6 | Function field of the held instruction |
| zero | input | 1 | ALU zero flag |
| iord | output | 1 | Memory address select: 0 PC, 1 ALU result register |
| mem_to_reg | output | 1 | Writeback data select: 1 memory data, 0 ALU result |
| reg_dst | output | 1 | Destination select: 1 rd, 0 rt |
| ir_wr | output | 1 | Instruction register load |
| mem_wr | output | 1 | Memory write |
| reg_wr | output | 1 | Register file write |
| alu_src_a | output | 1 | ALU A select: 0 PC, 1 register A |
| alu_src_b | output | 2 | ALU B select: 00 register B, 01 constant 4, 10 immediate, 11 immediate shifted by 2 |
| pc_src | output | 2 | Next PC select: 00 ALU result, 01 ALU output register, 10 jump address |
| alu_ctrl | output | 3 | ALU operation code |
| pc_en | output | 1 | Program counter load enable |

## Verification
The hardest cases to reach are the zero flag's narrow influence and an interrupted instruction. `zero` must move `pc_en` in the one BEQ compare cycle and nowhere else. The stimulus therefore holds `zero` high through whole R-type and BEQ instructions as well as low, and compares `pc_en` in every cycle. For the interruption, the bench drives a load as far as its memory read step and then pulls reset within that cycle. It checks that fetch controls appear before the next edge and that a normal instruction follows the release.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

    localparam int OP_W   = 6;
    localparam int FN_W   = 6;
    localparam int ALUC_W = 3;
    localparam int SRCB_W = 2;
    localparam int PCS_W  = 2;

    localparam logic [OP_W-1:0] OP_RTYPE = 6'b000000;
    localparam logic [OP_W-1:0] OP_ADDI  = 6'b001000;
    localparam logic [OP_W-1:0] OP_LW    = 6'b100011;
    localparam logic [OP_W-1:0] OP_SW    = 6'b101011;
    localparam logic [OP_W-1:0] OP_BEQ   = 6'b000100;
    localparam logic [OP_W-1:0] OP_J     = 6'b000010;

    localparam logic [FN_W-1:0] FN_ADD = 6'h20;
    localparam logic [FN_W-1:0] FN_SUB = 6'h22;
    localparam logic [FN_W-1:0] FN_AND = 6'h24;
    localparam logic [FN_W-1:0] FN_OR  = 6'h25;
    localparam logic [FN_W-1:0] FN_SLT = 6'h2A;

    localparam logic [ALUC_W-1:0] AC_AND = 3'b000;
    localparam logic [ALUC_W-1:0] AC_OR  = 3'b001;
    localparam logic [ALUC_W-1:0] AC_ADD = 3'b010;
    localparam logic [ALUC_W-1:0] AC_SUB = 3'b110;
    localparam logic [ALUC_W-1:0] AC_SLT = 3'b111;

    localparam logic [SRCB_W-1:0] SB_REG  = 2'b00;
    localparam logic [SRCB_W-1:0] SB_FOUR = 2'b01;
    localparam logic [SRCB_W-1:0] SB_IMM  = 2'b10;
    localparam logic [SRCB_W-1:0] SB_IMM4 = 2'b11;

    localparam logic [PCS_W-1:0] PS_ALU  = 2'b00;
    localparam logic [PCS_W-1:0] PS_AOUT = 2'b01;
    localparam logic [PCS_W-1:0] PS_JUMP = 2'b10;

    typedef enum logic [3:0] {
        ST_FETCH, ST_DECODE, ST_MADDR, ST_MREAD, ST_LDWB, ST_MWRITE,
        ST_REXEC, ST_RWB, ST_BRCMP, ST_IEXEC, ST_IWB, ST_JMP
    } ctl_state_e;

    typedef enum logic [1:0] {
        AOP_ADD   = 2'b00,
        AOP_SUB   = 2'b01,
        AOP_FUNCT = 2'b10
    } alu_op_e;

    typedef struct packed {
        logic              iord;
        logic              mem_to_reg;
        logic              reg_dst;
        logic              ir_wr;
        logic              mem_wr;
        logic              reg_wr;
        logic              pc_write;
        logic              branch;
        logic              src_a;
        logic [SRCB_W-1:0] src_b;
        logic [PCS_W-1:0]  pc_src;
        alu_op_e           alu_op;
    } ctl_word_t;

    typedef struct packed {
        ctl_state_e state;
    } fsm_reg_t;

endpackage

// File: rtl/mcc_main_fsm.sv
module mcc_main_fsm
    import mcc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] opcode,
    output ctl_state_e      state
);

    fsm_reg_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q.state)
            ST_FETCH:  fsm_d.state = ST_DECODE;
            ST_DECODE: begin
                case (opcode)
                    OP_LW, OP_SW: fsm_d.state = ST_MADDR;
                    OP_RTYPE:     fsm_d.state = ST_REXEC;
                    OP_BEQ:       fsm_d.state = ST_BRCMP;
                    OP_ADDI:      fsm_d.state = ST_IEXEC;
                    OP_J:         fsm_d.state = ST_JMP;
                    default:      fsm_d.state = ST_FETCH;
                endcase
            end
            ST_MADDR:  fsm_d.state = (opcode == OP_LW) ? ST_MREAD : ST_MWRITE;
            ST_MREAD:  fsm_d.state = ST_LDWB;
            ST_REXEC:  fsm_d.state = ST_RWB;
            ST_IEXEC:  fsm_d.state = ST_IWB;
            default:   fsm_d.state = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= '{state: ST_FETCH};
        else        fsm_q <= fsm_d;
    end

    assign state = fsm_q.state;

endmodule

// File: rtl/mcc_ctl_decode.sv
module mcc_ctl_decode
    import mcc_pkg::*;
(
    input  ctl_state_e state,
    output ctl_word_t  word
);

    always_comb begin
        word        = '0;
        word.alu_op = AOP_ADD;
        unique case (state)
            ST_FETCH: begin
                word.ir_wr    = 1'b1;
                word.pc_write = 1'b1;
                word.src_b    = SB_FOUR;
                word.pc_src   = PS_ALU;
            end
            ST_DECODE: word.src_b = SB_IMM4;
            ST_MADDR, ST_IEXEC: begin
                word.src_a = 1'b1;
                word.src_b = SB_IMM;
            end
            ST_MREAD: word.iord = 1'b1;
            ST_LDWB: begin
                word.mem_to_reg = 1'b1;
                word.reg_wr     = 1'b1;
            end
            ST_MWRITE: begin
                word.iord   = 1'b1;
                word.mem_wr = 1'b1;
            end
            ST_REXEC: begin
                word.src_a  = 1'b1;
                word.src_b  = SB_REG;
                word.alu_op = AOP_FUNCT;
            end
            ST_RWB: begin
                word.reg_dst = 1'b1;
                word.reg_wr  = 1'b1;
            end
            ST_BRCMP: begin
                word.src_a  = 1'b1;
                word.src_b  = SB_REG;
                word.alu_op = AOP_SUB;
                word.branch = 1'b1;
                word.pc_src = PS_AOUT;
            end
            ST_IWB: word.reg_wr = 1'b1;
            ST_JMP: begin
                word.pc_write = 1'b1;
                word.pc_src   = PS_JUMP;
            end
            default: word = '0;
        endcase
    end

endmodule

// File: rtl/mcc_alu_dec.sv
module mcc_alu_dec
    import mcc_pkg::*;
(
    input  alu_op_e           alu_op,
    input  logic [FN_W-1:0]   funct,
    output logic [ALUC_W-1:0] alu_ctrl
);

    logic [ALUC_W-1:0] fn_code;

    always_comb begin
        case (funct)
            FN_ADD:  fn_code = AC_ADD;
            FN_SUB:  fn_code = AC_SUB;
            FN_AND:  fn_code = AC_AND;
            FN_OR:   fn_code = AC_OR;
            FN_SLT:  fn_code = AC_SLT;
            default: fn_code = AC_ADD;
        endcase
    end

    always_comb begin
        case (alu_op)
            AOP_SUB:   alu_ctrl = AC_SUB;
            AOP_FUNCT: alu_ctrl = fn_code;
            default:   alu_ctrl = AC_ADD;
        endcase
    end

endmodule

// File: rtl/mcc_ctrl_unit.sv
module mcc_ctrl_unit
    import mcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   opcode,
    input  logic [FN_W-1:0]   funct,
    input  logic              zero,
    output logic              iord,
    output logic              mem_to_reg,
    output logic              reg_dst,
    output logic              ir_wr,
    output logic              mem_wr,
    output logic              reg_wr,
    output logic              alu_src_a,
    output logic [SRCB_W-1:0] alu_src_b,
    output logic [PCS_W-1:0]  pc_src,
    output logic [ALUC_W-1:0] alu_ctrl,
    output logic              pc_en
);

    ctl_state_e state;
    ctl_word_t  word;

    mcc_main_fsm i_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .opcode (opcode),
        .state  (state)
    );

    mcc_ctl_decode i_dec (
        .state (state),
        .word  (word)
    );

    mcc_alu_dec i_alu_dec (
        .alu_op   (word.alu_op),
        .funct    (funct),
        .alu_ctrl (alu_ctrl)
    );

    assign iord       = word.iord;
    assign mem_to_reg = word.mem_to_reg;
    assign reg_dst    = word.reg_dst;
    assign ir_wr      = word.ir_wr;
    assign mem_wr     = word.mem_wr;
    assign reg_wr     = word.reg_wr;
    assign alu_src_a  = word.src_a;
    assign alu_src_b  = word.src_b;
    assign pc_src     = word.pc_src;
    assign pc_en      = word.pc_write | (word.branch & zero);

endmodule

// File: rtl/mcc_ctrl_chk.sv
module mcc_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       iord,
    input logic       ir_wr,
    input logic       mem_wr,
    input logic       reg_wr,
    input logic [1:0] alu_src_b,
    input logic [1:0] pc_src,
    input logic       pc_en
);

    p_fetch_controls_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ir_wr |-> (!iord && alu_src_b == 2'b01 && pc_src == 2'b00 && pc_en));

    p_fetch_then_decode_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ir_wr |=> (!ir_wr && alu_src_b == 2'b11));

    p_write_ends_instr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr || mem_wr) |=> ir_wr);

    p_store_uses_alu_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> iord);

    p_one_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ir_wr, reg_wr, mem_wr}));

    p_no_pc_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ir_wr && pc_src == 2'b00) |-> !pc_en);

    p_redirect_ends_instr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_src != 2'b00) |=> ir_wr);

endmodule

bind mcc_ctrl_unit mcc_ctrl_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .iord      (iord),
    .ir_wr     (ir_wr),
    .mem_wr    (mem_wr),
    .reg_wr    (reg_wr),
    .alu_src_b (alu_src_b),
    .pc_src    (pc_src),
    .pc_en     (pc_en)
);

// File: tb/test_mcc_ctrl_unit.sv
`timescale 1ns/100ps
module test_mcc_ctrl_unit;

    localparam int WDOG_CYC = 5000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] opcode = 6'd0;
    logic [5:0] funct = 6'd0;
    logic       zero = 1'b0;
    logic       iord, mem_to_reg, reg_dst, ir_wr, mem_wr, reg_wr, alu_src_a, pc_en;
    logic [1:0] alu_src_b, pc_src;
    logic [2:0] alu_ctrl;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [14:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    mcc_ctrl_unit i_mcc_ctrl_unit (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .funct(funct), .zero(zero),
        .iord(iord), .mem_to_reg(mem_to_reg), .reg_dst(reg_dst), .ir_wr(ir_wr),
        .mem_wr(mem_wr), .reg_wr(reg_wr), .alu_src_a(alu_src_a),
        .alu_src_b(alu_src_b), .pc_src(pc_src), .alu_ctrl(alu_ctrl), .pc_en(pc_en)
    );

    // word = {iord, m2r, rdst, irw, memw, regw, srca, srcb, pcsrc, alu, pcen}
    function automatic logic [14:0] mk(input logic io, input logic m2r, input logic rd,
        input logic irw, input logic mw, input logic rw, input logic sa,
        input logic [1:0] sb, input logic [1:0] ps, input logic [2:0] al, input logic pe);
        return {io, m2r, rd, irw, mw, rw, sa, sb, ps, al, pe};
    endfunction

    function automatic logic [2:0] ref_alu(input logic [5:0] fn);
        case (fn)
            6'h20:   return 3'b010;
            6'h22:   return 3'b110;
            6'h24:   return 3'b000;
            6'h25:   return 3'b001;
            6'h2A:   return 3'b111;
            default: return 3'b010;
        endcase
    endfunction

    function automatic logic [14:0] e_fetch();  return mk(0,0,0,1,0,0,0,2'b01,2'b00,3'b010,1); endfunction
    function automatic logic [14:0] e_decode(); return mk(0,0,0,0,0,0,0,2'b11,2'b00,3'b010,0); endfunction
    function automatic logic [14:0] e_addr();   return mk(0,0,0,0,0,0,1,2'b10,2'b00,3'b010,0); endfunction
    function automatic logic [14:0] e_mread();  return mk(1,0,0,0,0,0,0,2'b00,2'b00,3'b010,0); endfunction
    function automatic logic [14:0] e_ldwb();   return mk(0,1,0,0,0,1,0,2'b00,2'b00,3'b010,0); endfunction
    function automatic logic [14:0] e_mwrite(); return mk(1,0,0,0,1,0,0,2'b00,2'b00,3'b010,0); endfunction
    function automatic logic [14:0] e_rwb();    return mk(0,0,1,0,0,1,0,2'b00,2'b00,3'b010,0); endfunction
    function automatic logic [14:0] e_iwb();    return mk(0,0,0,0,0,1,0,2'b00,2'b00,3'b010,0); endfunction
    function automatic logic [14:0] e_jmp();    return mk(0,0,0,0,0,0,0,2'b00,2'b10,3'b010,1); endfunction

    task automatic step(input logic [14:0] w, input string tag);
        exp_q.push_back(w);
        tag_q.push_back(tag);
        @(posedge clk);
        #1;
    endtask

    task automatic run_instr(input logic [5:0] op, input logic [5:0] fn, input logic z, input string tag);
        opcode = op;
        funct  = fn;
        zero   = z;
        step(e_fetch(),  {tag, " fetch R1 R5"});
        step(e_decode(), {tag, " decode R6 R9"});
        case (op)
            6'b000000: begin
                step(mk(0,0,0,0,0,0,1,2'b00,2'b00,ref_alu(fn),0), {tag, " exec R8 R9"});
                step(e_rwb(), {tag, " wb R7"});
            end
            6'b001000: begin
                step(e_addr(), {tag, " exec R6"});
                step(e_iwb(),  {tag, " wb R7"});
            end
            6'b100011: begin
                step(e_addr(),  {tag, " addr R6"});
                step(e_mread(), {tag, " read R4"});
                step(e_ldwb(),  {tag, " wb R7"});
            end
            6'b101011: begin
                step(e_addr(),   {tag, " addr R6"});
                step(e_mwrite(), {tag, " write R4 R5"});
            end
            6'b000100: step(mk(0,0,0,0,0,0,1,2'b00,2'b01,3'b110,z), {tag, " compare R9 R10"});
            6'b000010: step(e_jmp(), {tag, " jump R10"});
            default: ; // R3: back to fetch after decode
        endcase
    endtask

    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [14:0] act;
            logic [14:0] exp;
            string       tg;
            act = {iord, mem_to_reg, reg_dst, ir_wr, mem_wr, reg_wr, alu_src_a,
                   alu_src_b, pc_src, alu_ctrl, pc_en};
            exp = exp_q.pop_front();
            tg  = tag_q.pop_front();
            n_cmp++;
            if (act !== exp) begin
                n_bad++;
                $display("FAIL %s: actual %b expected %b", tg, act, exp);
            end
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        #1;
        step(e_fetch(), "R1 reset state");
        rst_n = 1'b1;

        run_instr(6'b000000, 6'h20, 1'b0, "R2 R8 add");
        run_instr(6'b000000, 6'h22, 1'b1, "R8 R9 sub zero high");
        run_instr(6'b000000, 6'h24, 1'b0, "R8 and");
        run_instr(6'b000000, 6'h25, 1'b1, "R8 or");
        run_instr(6'b000000, 6'h2A, 1'b0, "R8 slt");
        run_instr(6'b000000, 6'h27, 1'b0, "R8 unknown funct");
        run_instr(6'b001000, 6'h22, 1'b1, "R2 R7 addi");
        run_instr(6'b100011, 6'h2A, 1'b1, "R2 R4 lw");
        run_instr(6'b101011, 6'h00, 1'b0, "R2 R5 sw");
        run_instr(6'b000100, 6'h25, 1'b1, "R9 beq taken");
        run_instr(6'b000100, 6'h20, 1'b0, "R9 beq not taken");
        run_instr(6'b000010, 6'h00, 1'b1, "R10 jump");
        run_instr(6'b111111, 6'h20, 1'b1, "R3 illegal 3f");
        run_instr(6'b000101, 6'h00, 1'b0, "R3 illegal 05");
        run_instr(6'b000000, 6'h24, 1'b1, "R11 after illegal");

        // R12: reset during the load read step
        opcode = 6'b100011;
        zero   = 1'b0;
        step(e_fetch(),  "R12 lw fetch");
        step(e_decode(), "R12 lw decode");
        step(e_addr(),   "R12 lw addr");
        rst_n = 1'b0;
        step(e_fetch(),  "R12 fetch under reset");
        rst_n = 1'b1;
        run_instr(6'b101011, 6'h00, 1'b0, "R12 sw after reset");
        run_instr(6'b000100, 6'h00, 1'b1, "R12 beq after reset");

        while (exp_q.size() > 0) @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule